// File: doc/BRIEF.md
# Two-Stage UART Baud Rate Generator

This block turns the system clock into the two timing strobes a UART needs: a sample enable for the receiver's oversampling and a bit enable for shifting serial data. The reference clock is the system clock itself, optionally pre-divided by eight. A 16-bit first stage divides the reference into sample enables. An 8-bit second stage counts those sample enables and emits a bit enable on every (second divisor + 1)-th one. The resulting bit rate is reference / (first divisor × (second divisor + 1)).

Software programs the two divisors and the pre-divide bit through a plain write port. It has an 8-bit byte address, 16-bit data and a one-cycle write strobe. The port has no read path and no handshake, because configuration is not a data stream. Every write to a mapped address restarts all internal counting. The first bit period after a reprogramming is therefore always a full period and is never cut short by a stale partial count.

Top module: `baudgen_two_stage`

## Requirements
- R1: After reset both enables are low. The first divisor is 0, the second divisor is 4 and the pre-divide is off, so no enable pulses until the block is configured.
- R2: With pre-divide off and a first divisor N ≥ 1, sample_en pulses exactly N clocks after the configuring write and every N clocks after that. N = 1 holds sample_en high on every clock.
- R3: A first divisor of 0 stops both sample_en and baud_en.
- R4: baud_en is high only together with sample_en, on every (D+1)-th sample pulse counted from the last restart, where D is the second divisor.
- R5: A write to address 0x34 loads the second divisor from data bits [7:0]. A value below 4 is stored as 4, and data bits [15:8] are ignored.
- R6: A write to address 0x04 loads the pre-divide select from data bit 0. When it is 1, the reference advances once every 8 clocks, so sample_en comes every 8×N clocks.
- R7: A write to 0x18 (first divisor, data bits [15:0]), 0x34 or 0x04 restarts all counters. The next pulses then come exactly one full period after the write clock edge.
- R8: Writes to any other address change neither the settings nor the phase of the pulse train.
- R9: When the sample period is longer than one clock, each sample_en and baud_en pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider reference |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 16 | Configuration write data |
| sample_en | output | 1 | Oversampling enable pulse |
| baud_en | output | 1 | Bit-rate enable pulse |

## Verification
The bound checker checks these on every cycle:
- baud_en never appears without sample_en;
- a zero first divisor keeps sample_en low;
- the stored second divisor never drops below its floor;
- both enables are low on the clock after any mapped write;
- with pre-divide on, pulses never come back to back.

Only the bench's scenarios show the exact periods and phases: the N-clock and 8×N-clock spacing, the (D+1) ratio, clamping and the ignored upper bits, and the full first period after a restart in the middle of a count. They also show that writes to unmapped addresses leave the phase untouched. The bench shows all of these by comparing both enables on every clock against a closed-form model built on the count of clocks since the last restart.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_GEN  = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 8'h34;

  typedef struct packed {
    logic             presel;
    logic [15:0]      gen;
    logic [7:0]       div;
  } bgen_cfg_t;
endpackage

// File: rtl/bgen_cfg_regs.sv
module bgen_cfg_regs
  import bgen_pkg::*;
#(
  parameter int GEN_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [GEN_W-1:0]  gen_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              presel_q,
  output logic              restart
);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(DIV_MIN);

  logic hit_gen, hit_div, hit_mode;
  logic [DIV_W-1:0] div_in;

  assign hit_gen  = cfg_we && (cfg_addr == ADDR_GEN);
  assign hit_div  = cfg_we && (cfg_addr == ADDR_DIV);
  assign hit_mode = cfg_we && (cfg_addr == ADDR_MODE);
  assign restart  = hit_gen || hit_div || hit_mode;

  // Floor on the second-stage divisor keeps the bit period legal.
  assign div_in = (cfg_wdata[DIV_W-1:0] < DIV_FLOOR) ? DIV_FLOOR
                                                     : cfg_wdata[DIV_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q    <= '0;
      div_q    <= DIV_FLOOR;
      presel_q <= 1'b0;
    end else begin
      if (hit_gen)  gen_q    <= cfg_wdata[GEN_W-1:0];
      if (hit_div)  div_q    <= div_in;
      if (hit_mode) presel_q <= cfg_wdata[0];
    end
  end
endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
  parameter int PRE_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic presel,
  output logic ref_en
);
  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int PC_W = $clog2(PRE_DIV);
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRE_DIV - 1);
      logic [PC_W-1:0] pc;
      always_ff @(posedge clk) begin
        if (!rst_n || restart) pc <= '0;
        else if (pc == PC_LAST) pc <= '0;
        else pc <= pc + 1'b1;
      end
      assign ref_en = presel ? (pc == PC_LAST) : 1'b1;
    end else begin : g_pass
      assign ref_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/bgen_sample_div.sv
module bgen_sample_div #(
  parameter int GEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             ref_en,
  input  logic [GEN_W-1:0] gen,
  output logic             wrap,
  output logic             sample_q
);
  logic [GEN_W-1:0] cnt;

  assign wrap = ref_en && (gen != '0) && (cnt == gen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt      <= '0;
      sample_q <= 1'b0;
    end else begin
      sample_q <= wrap;
      if (wrap) cnt <= '0;
      else if (ref_en && gen != '0) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bgen_baud_div.sv
module bgen_baud_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             baud_q
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt    <= '0;
      baud_q <= 1'b0;
    end else if (tick) begin
      if (cnt == div) begin
        cnt    <= '0;
        baud_q <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        baud_q <= 1'b0;
      end
    end else begin
      baud_q <= 1'b0;
    end
  end
endmodule

// File: rtl/baudgen_two_stage.sv
module baudgen_two_stage
  import bgen_pkg::*;
#(
  parameter int GEN_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 4,
  parameter int PRE_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              sample_en,
  output logic              baud_en
);
  logic [GEN_W-1:0] gen_q;
  logic [DIV_W-1:0] div_q;
  logic presel_q, restart, ref_en, s1_wrap;

  bgen_cfg_regs #(.GEN_W(GEN_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gen_q(gen_q), .div_q(div_q),
    .presel_q(presel_q), .restart(restart)
  );

  bgen_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .presel(presel_q),
    .ref_en(ref_en)
  );

  bgen_sample_div #(.GEN_W(GEN_W)) u_s1 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .ref_en(ref_en),
    .gen(gen_q), .wrap(s1_wrap), .sample_q(sample_en)
  );

  // Second stage sees the same wrap the first stage registers, so a
  // bit enable always lands on the clock of a sample enable.
  bgen_baud_div #(.DIV_W(DIV_W)) u_s2 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(s1_wrap),
    .div(div_q), .baud_q(baud_en)
  );
endmodule

// File: rtl/bgen_checker.sv
module bgen_checker
  import bgen_pkg::*;
#(
  parameter int GEN_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              sample_en,
  input logic              baud_en,
  input logic [GEN_W-1:0]  gen_val,
  input logic [DIV_W-1:0]  div_val,
  input logic              presel_val
);
  logic mapped_wr;
  assign mapped_wr = cfg_we && (cfg_addr == ADDR_GEN || cfg_addr == ADDR_DIV ||
                                cfg_addr == ADDR_MODE);

  p_baud_with_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |-> sample_en);

  p_zero_gen_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_val == '0) |-> (!sample_en && !baud_en));

  p_div_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_val >= DIV_W'(DIV_MIN));

  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mapped_wr |=> (!sample_en && !baud_en));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (presel_val && sample_en) |=> !sample_en);

  p_baud_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |=> !baud_en);
endmodule

bind baudgen_two_stage bgen_checker #(
  .GEN_W(GEN_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .sample_en(sample_en), .baud_en(baud_en), .gen_val(gen_q),
  .div_val(div_q), .presel_val(presel_q)
);

// File: tb/baudgen_two_stage_tb.sv
module baudgen_two_stage_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic sample_en, baud_en;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference model state
  int m_gen = 0;
  int m_div = 4;
  int m_pre = 0;
  int t = 0;

  always #4 clk = ~clk;

  baudgen_two_stage dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sample_en(sample_en), .baud_en(baud_en)
  );

  function automatic int clamp_div(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gen = 0; m_div = 4; m_pre = 0; t = 0;
    end else if (cfg_we && (cfg_addr == 8'h18 || cfg_addr == 8'h34 ||
                            cfg_addr == 8'h04)) begin
      if (cfg_addr == 8'h18) m_gen = int'(cfg_wdata);
      if (cfg_addr == 8'h34) m_div = clamp_div(int'(cfg_wdata[7:0]));
      if (cfg_addr == 8'h04) m_pre = int'(cfg_wdata[0]);
      t = 0;
    end else begin
      t = t + 1;
    end
  end

  function automatic bit exp_sample();
    int p;
    p = (m_pre != 0 ? 8 : 1) * m_gen;
    return (m_gen != 0) && (t > 0) && (t % p == 0);
  endfunction

  function automatic bit exp_baud();
    int p;
    p = (m_pre != 0 ? 8 : 1) * m_gen * (m_div + 1);
    return exp_sample() && (t % p == 0);
  endfunction

  task automatic check(input string req, input string what,
                       input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at t=%0d: actual=%0b expected=%0b",
               req, what, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "sample_en", sample_en, exp_sample());
      check(cur_req, "baud_en", baud_en, exp_baud());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset sample_en", sample_en, 1'b0);
    check("R1", "reset baud_en", baud_en, 1'b0);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(30);

    // R2 / R4: divisor 3, second stage 4 -> bit every 15 clocks
    cur_req = "R2";
    wr(8'h18, 16'd3);
    idle(100);
    cur_req = "R4";
    wr(8'h34, 16'd6);
    idle(120);

    // R2: divisor 1 is a pass-through
    cur_req = "R2";
    wr(8'h18, 16'd1);
    idle(40);

    // R3: zero stops everything
    cur_req = "R3";
    wr(8'h18, 16'd0);
    idle(60);

    // R5: clamp and upper bits ignored
    cur_req = "R5";
    wr(8'h18, 16'd2);
    wr(8'h34, 16'd2);
    idle(60);
    wr(8'h34, 16'h1F07);
    idle(60);
    wr(8'h34, 16'd0);
    idle(40);

    // R6: pre-divide by 8
    cur_req = "R6";
    wr(8'h04, 16'hFFFE);
    idle(20);
    wr(8'h04, 16'h0001);
    idle(200);

    // R9: single-clock pulses with longer periods
    cur_req = "R9";
    wr(8'h18, 16'd5);
    idle(150);
    wr(8'h04, 16'h0000);
    idle(80);

    // R7: restart in the middle of a count
    cur_req = "R7";
    wr(8'h18, 16'd7);
    idle(10);
    wr(8'h18, 16'd7);
    idle(3);
    wr(8'h34, 16'd4);
    idle(80);

    // R8: unmapped writes leave phase alone
    cur_req = "R8";
    idle(4);
    wr(8'h08, 16'd1);
    idle(5);
    wr(8'h19, 16'd0);
    wr(8'h35, 16'd0);
    idle(100);

    // R2: a larger first divisor
    cur_req = "R2";
    wr(8'h18, 16'd300);
    idle(1600);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule